// File: doc/BRIEF.md
# Instruction Dispatch Gate

The dispatch gate sits between decode and the out-of-order back end. Every cycle it looks at the decoded instruction at the head of the decode queue. It decides in the same cycle whether that instruction may enter the back end, and it raises a dispatch strobe when it may. Three checks apply:

- The rename tracker must have enough free slots for the instruction's register writes.
- The retire queue must have enough free slots for its micro-ops.
- The scheduler must report that it can accept the instruction.

Dispatch bandwidth is counted in micro-ops. Each cycle offers `DISP_W` entries. An instruction with more micro-ops than that takes the whole width and leaves the surplus as a carry-over, which drains over the following cycles.

When a valid instruction is refused, the refusal is charged to exactly one cause. Each cause has its own saturating counter, so performance analysis can see why the front end stalled. The carry-over count is also brought out so the back end can follow the multi-cycle dispatch.

Top module: `dispatch_gate`

## Requirements
- R1: After synchronous reset (`rst` high at a clock edge), `carry` is 0 and all seven stall counters are 0.
- R2: A valid instruction with `in_uops` no larger than the entries free this cycle, and with no other check failing, gets `disp` high in the same cycle. The free entries are `DISP_W` minus the carry-over drained this cycle.
- R3: An instruction with `in_uops > DISP_W` dispatches only when `carry` is 0. On the next cycle `carry` equals `in_uops - DISP_W`.
- R4: While `carry > DISP_W`, nothing dispatches and `carry` drops by `DISP_W` each cycle. When `0 < carry <= DISP_W`, `carry` goes to 0 at the next edge, and the `DISP_W - carry` entries left over are usable in that same cycle.
- R5: `in_writes > ren_free` blocks dispatch and increments the rename counter, which is slot 0.
- R6: `max(in_uops,1) > rq_free` blocks dispatch and increments the retire-queue counter, which is slot 1.
- R7: `sch_code` 0 means the scheduler accepts. Code 1 increments slot 2 (scheduler queue full), code 2 increments slot 3 (load queue full) and code 3 increments slot 4 (store queue full). Codes 4 to 7 increment slot 5 (group restriction). Every non-zero code blocks dispatch.
- R8: Checks are ranked rename, retire queue, scheduler, bandwidth. Only the highest-ranked failing cause is counted in a cycle.
- R9: A refusal caused only by bandwidth (R2/R3/R4) increments slot 6.
- R10: Stall counters saturate at 65535 and do not wrap.
- R11: With `in_valid` low, `disp` stays low and no counter changes.
- R12: A zero micro-op instruction needs one retire-queue slot and no dispatch entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A decoded instruction is presented |
| in_uops | input | UOP_W | Micro-op count of the instruction |
| in_writes | input | WR_W | Register writes of the instruction |
| ren_free | input | RF_W | Free slots in the rename tracker |
| rq_free | input | RQ_W | Free slots in the retire queue |
| sch_code | input | 3 | Scheduler acceptance status (see R7) |
| disp | output | 1 | Instruction dispatched this cycle |
| carry | output | UOP_W | Outstanding carry-over micro-ops |
| stall_cnt | output | 7*CNT_W | Stall counters; slot k occupies bits [k*CNT_W +: CNT_W] |

## Verification
Instructions of one to four micro-ops, and of zero micro-ops, exercise the plain bandwidth path. Zero micro-op instructions against an empty retire queue separate the entry count from the retire-slot count. Oversized instructions are followed by both fitting and oversized instructions while the carry drains, which separates "carry still outstanding" from "carry draining with leftover entries". Several checks are made to fail at once to confirm the priority ranking. A long run of rename stalls drives one counter into saturation.

// File: rtl/dispatch_gate_pkg.sv
package dispatch_gate_pkg;

   localparam int NCAUSE = 7;

   typedef enum logic [2:0] {
      CS_RENAME = 3'd0,
      CS_RETIRE = 3'd1,
      CS_SCHQ   = 3'd2,
      CS_LDQ    = 3'd3,
      CS_STQ    = 3'd4,
      CS_GROUP  = 3'd5,
      CS_WIDTH  = 3'd6
   } cause_e;

   typedef enum logic [2:0] {
      SCH_OK   = 3'd0,
      SCH_SQ   = 3'd1,
      SCH_LDQ  = 3'd2,
      SCH_STQ  = 3'd3
   } sch_e;

endpackage

// File: rtl/dg_bandwidth.sv
module dg_bandwidth #(
   parameter int DISP_W = 4,
   parameter int UOP_W  = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [UOP_W-1:0] in_uops,
   input  logic             take,
   output logic             width_ok,
   output logic [UOP_W-1:0] carry
);
   localparam logic [UOP_W-1:0] W_U = UOP_W'(DISP_W);

   logic [UOP_W-1:0] carry_q, carry_d, drain, avail;
   logic             busy, oversized;

   always_comb begin
      busy      = carry_q > W_U;
      drain     = busy ? W_U : carry_q;
      avail     = W_U - drain;
      oversized = in_uops > W_U;
      width_ok  = !busy && (oversized ? (carry_q == '0) : (in_uops <= avail));
      if (take && oversized)
         carry_d = in_uops - W_U;
      else if (busy)
         carry_d = carry_q - W_U;
      else
         carry_d = '0;
   end

   always_ff @(posedge clk) begin
      if (rst) carry_q <= '0;
      else     carry_q <= carry_d;
   end

   assign carry = carry_q;
endmodule

// File: rtl/dg_cause_sel.sv
module dg_cause_sel
   import dispatch_gate_pkg::*;
#(
   parameter int UOP_W = 4,
   parameter int WR_W  = 3,
   parameter int RF_W  = 5,
   parameter int RQ_W  = 6
) (
   input  logic              in_valid,
   input  logic [UOP_W-1:0]  in_uops,
   input  logic [WR_W-1:0]   in_writes,
   input  logic [RF_W-1:0]   ren_free,
   input  logic [RQ_W-1:0]   rq_free,
   input  logic [2:0]        sch_code,
   input  logic              width_ok,
   output logic [NCAUSE-1:0] stall_vec,
   output logic              go
);
   localparam int RN_CW = (WR_W > RF_W) ? WR_W : RF_W;
   localparam int RQ_CW = (UOP_W > RQ_W) ? UOP_W : RQ_W;

   logic [RQ_CW-1:0] need_rq;
   logic             ren_fail, rq_fail, sch_fail;
   cause_e           sch_cause;

   always_comb begin
      need_rq  = (in_uops == '0) ? RQ_CW'(1) : RQ_CW'(in_uops);
      ren_fail = RN_CW'(in_writes) > RN_CW'(ren_free);
      rq_fail  = need_rq > RQ_CW'(rq_free);
      sch_fail = sch_code != SCH_OK;
      case (sch_code)
         SCH_SQ:  sch_cause = CS_SCHQ;
         SCH_LDQ: sch_cause = CS_LDQ;
         SCH_STQ: sch_cause = CS_STQ;
         default: sch_cause = CS_GROUP;
      endcase

      stall_vec = '0;
      go        = 1'b0;
      if (in_valid) begin
         if (ren_fail)       stall_vec[CS_RENAME] = 1'b1;
         else if (rq_fail)   stall_vec[RQ_CW > 0 ? CS_RETIRE : CS_RETIRE] = 1'b1;
         else if (sch_fail)  stall_vec[sch_cause] = 1'b1;
         else if (!width_ok) stall_vec[CS_WIDTH] = 1'b1;
         else                go = 1'b1;
      end
   end
endmodule

// File: rtl/dg_stall_ctrs.sv
module dg_stall_ctrs #(
   parameter int NUM   = 7,
   parameter int CNT_W = 16
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [NUM-1:0]       bump,
   output logic [NUM*CNT_W-1:0] cnt_flat
);
   for (genvar k = 0; k < NUM; k++) begin : g_ctr
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk) begin
         if (rst)
            cnt_q <= '0;
         else if (bump[k] && (cnt_q != {CNT_W{1'b1}}))
            cnt_q <= cnt_q + 1'b1;
      end
      assign cnt_flat[k*CNT_W +: CNT_W] = cnt_q;
   end
endmodule

// File: rtl/dispatch_gate.sv
module dispatch_gate
   import dispatch_gate_pkg::*;
#(
   parameter int DISP_W = 4,
   parameter int UOP_W  = 4,
   parameter int WR_W   = 3,
   parameter int RF_W   = 5,
   parameter int RQ_W   = 6,
   parameter int CNT_W  = 16
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    in_valid,
   input  logic [UOP_W-1:0]        in_uops,
   input  logic [WR_W-1:0]         in_writes,
   input  logic [RF_W-1:0]         ren_free,
   input  logic [RQ_W-1:0]         rq_free,
   input  logic [2:0]              sch_code,
   output logic                    disp,
   output logic [UOP_W-1:0]        carry,
   output logic [NCAUSE*CNT_W-1:0] stall_cnt
);
   initial begin
      assert (DISP_W >= 1) else $error("DISP_W must be at least 1");
      assert (DISP_W < (1 << UOP_W)) else $error("UOP_W too narrow for DISP_W");
      assert (CNT_W >= 2) else $error("CNT_W must be at least 2");
   end

   logic              width_ok;
   logic [NCAUSE-1:0] stall_vec;
   logic              go;

   dg_bandwidth #(.DISP_W(DISP_W), .UOP_W(UOP_W)) u_bw (
      .clk      (clk),
      .rst      (rst),
      .in_uops  (in_uops),
      .take     (go),
      .width_ok (width_ok),
      .carry    (carry)
   );

   dg_cause_sel #(.UOP_W(UOP_W), .WR_W(WR_W), .RF_W(RF_W), .RQ_W(RQ_W)) u_sel (
      .in_valid  (in_valid),
      .in_uops   (in_uops),
      .in_writes (in_writes),
      .ren_free  (ren_free),
      .rq_free   (rq_free),
      .sch_code  (sch_code),
      .width_ok  (width_ok),
      .stall_vec (stall_vec),
      .go        (go)
   );

   dg_stall_ctrs #(.NUM(NCAUSE), .CNT_W(CNT_W)) u_ctr (
      .clk      (clk),
      .rst      (rst),
      .bump     (stall_vec),
      .cnt_flat (stall_cnt)
   );

   assign disp = go;
endmodule

// File: rtl/dispatch_gate_chk.sv
module dispatch_gate_chk #(
   parameter int DISP_W = 4,
   parameter int UOP_W  = 4,
   parameter int WR_W   = 3,
   parameter int RF_W   = 5,
   parameter int NC     = 7
) (
   input logic             clk,
   input logic             rst,
   input logic             in_valid,
   input logic [UOP_W-1:0] in_uops,
   input logic [WR_W-1:0]  in_writes,
   input logic [RF_W-1:0]  ren_free,
   input logic [2:0]       sch_code,
   input logic             disp,
   input logic [UOP_W-1:0] carry,
   input logic [NC-1:0]    stall_vec
);
   localparam logic [UOP_W-1:0] W_U = UOP_W'(DISP_W);
   localparam int CW = (WR_W > RF_W) ? WR_W : RF_W;

   // R8: at most one cause charged per cycle, never together with a dispatch
   p_one_cause_r8: assert property (@(posedge clk) disable iff (rst)
      $onehot0(stall_vec) && !(disp && (stall_vec != '0)));

   // R3: oversized dispatch leaves the surplus as carry
   p_carry_set_r3: assert property (@(posedge clk) disable iff (rst)
      (disp && (in_uops > W_U)) |=> (carry == $past(in_uops) - W_U));

   // R4: outstanding carry blocks dispatch and drains by the width
   p_carry_block_r4: assert property (@(posedge clk) disable iff (rst)
      (carry > W_U) |-> !disp);
   p_carry_drain_r4: assert property (@(posedge clk) disable iff (rst)
      (carry > W_U) |=> (carry == $past(carry) - W_U));

   // R5: rename shortage blocks dispatch
   p_rename_block_r5: assert property (@(posedge clk) disable iff (rst)
      (CW'(in_writes) > CW'(ren_free)) |-> !disp);

   // R7: any non-zero scheduler code blocks dispatch
   p_sched_block_r7: assert property (@(posedge clk) disable iff (rst)
      (sch_code != 3'd0) |-> !disp);

   // R11: nothing happens without a valid instruction
   p_idle_r11: assert property (@(posedge clk) disable iff (rst)
      !in_valid |-> (!disp && (stall_vec == '0)));
endmodule

bind dispatch_gate dispatch_gate_chk #(
   .DISP_W(DISP_W), .UOP_W(UOP_W), .WR_W(WR_W), .RF_W(RF_W), .NC(dispatch_gate_pkg::NCAUSE)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .in_uops   (in_uops),
   .in_writes (in_writes),
   .ren_free  (ren_free),
   .sch_code  (sch_code),
   .disp      (disp),
   .carry     (carry),
   .stall_vec (stall_vec)
);

// File: tb/dispatch_gate_bench.sv
module dispatch_gate_bench;
   localparam int DISP_W = 4;
   localparam int UOP_W  = 4;
   localparam int WR_W   = 3;
   localparam int RF_W   = 5;
   localparam int RQ_W   = 6;
   localparam int CNT_W  = 16;
   localparam int NC     = 7;
   localparam int CMAX   = (1 << CNT_W) - 1;

   logic                 clk = 1'b0;
   logic                 rst = 1'b1;
   logic                 in_valid = 1'b0;
   logic [UOP_W-1:0]     in_uops = '0;
   logic [WR_W-1:0]      in_writes = '0;
   logic [RF_W-1:0]      ren_free = '0;
   logic [RQ_W-1:0]      rq_free = '0;
   logic [2:0]           sch_code = '0;
   logic                 disp;
   logic [UOP_W-1:0]     carry;
   logic [NC*CNT_W-1:0]  stall_cnt;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   int m_carry = 0;
   int m_ctr[NC];

   string q_tag[$];
   int    q_carry[$];
   logic [NC*CNT_W-1:0] q_ctr[$];

   always #10 clk = ~clk;

   dispatch_gate #(.DISP_W(DISP_W), .UOP_W(UOP_W), .WR_W(WR_W), .RF_W(RF_W),
                   .RQ_W(RQ_W), .CNT_W(CNT_W)) u_dispatch_gate (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_uops(in_uops),
      .in_writes(in_writes), .ren_free(ren_free), .rq_free(rq_free),
      .sch_code(sch_code), .disp(disp), .carry(carry), .stall_cnt(stall_cnt));

   function automatic logic [NC*CNT_W-1:0] pack_ctr();
      logic [NC*CNT_W-1:0] v;
      for (int k = 0; k < NC; k++) v[k*CNT_W +: CNT_W] = CNT_W'(m_ctr[k]);
      return v;
   endfunction

   task automatic drive(input bit v, input int u, input int w, input int rf,
                        input int rq, input int sc, input string tag);
      int  cause;
      int  need;
      bit  busy;
      int  avail;
      bit  wok;
      bit  exp_d;
      @(negedge clk);
      in_valid = v; in_uops = UOP_W'(u); in_writes = WR_W'(w);
      ren_free = RF_W'(rf); rq_free = RQ_W'(rq); sch_code = 3'(sc);
      busy  = m_carry > DISP_W;
      avail = DISP_W - (busy ? DISP_W : m_carry);
      wok   = !busy && ((u > DISP_W) ? (m_carry == 0) : (u <= avail));
      need  = (u == 0) ? 1 : u;
      cause = -1;
      if (v) begin
         if (w > rf)         cause = 0;
         else if (need > rq) cause = 1;
         else if (sc != 0)   cause = (sc == 1) ? 2 : (sc == 2) ? 3 : (sc == 3) ? 4 : 5;
         else if (!wok)      cause = 6;
      end
      exp_d = v && (cause < 0);
      if (exp_d && u > DISP_W) m_carry = u - DISP_W;
      else if (busy)           m_carry = m_carry - DISP_W;
      else                     m_carry = 0;
      if (cause >= 0 && m_ctr[cause] < CMAX) m_ctr[cause]++;
      #1;
      checks++;
      if (disp !== exp_d) begin
         errors++;
         $display("FAIL %s disp actual %0b expected %0b", tag, disp, exp_d);
      end
      q_tag.push_back(tag);
      q_carry.push_back(m_carry);
      q_ctr.push_back(pack_ctr());
   endtask

   // monitor: compares registered state one edge after each driven cycle
   initial begin
      forever begin
         @(negedge clk);
         if (q_tag.size() > 0) begin
            string t;
            int ec;
            logic [NC*CNT_W-1:0] ev;
            t = q_tag.pop_front();
            ec = q_carry.pop_front();
            ev = q_ctr.pop_front();
            checks++;
            if ((int'(carry) != ec) || (stall_cnt !== ev)) begin
               errors++;
               $display("FAIL %s carry actual %0d expected %0d counters actual %h expected %h",
                        t, carry, ec, stall_cnt, ev);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int k = 0; k < NC; k++) m_ctr[k] = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      checks++;
      if (carry !== '0 || stall_cnt !== '0) begin
         errors++;
         $display("FAIL R1 reset carry actual %0d expected 0 counters actual %h expected 0",
                  carry, stall_cnt);
      end
      // R11 idle cycles, even with failing side conditions
      drive(0, 3, 7, 0, 0, 2, "R11");
      drive(0, 12, 0, 8, 32, 0, "R11");
      // R2 fitting instructions
      drive(1, 3, 1, 8, 32, 0, "R2");
      drive(1, 4, 2, 8, 32, 0, "R2");
      drive(1, 1, 0, 8, 32, 0, "R2");
      // R12 zero micro-ops
      drive(1, 0, 0, 8, 32, 0, "R12");
      drive(1, 0, 0, 8, 0, 0, "R12");
      drive(1, 0, 0, 8, 1, 0, "R12");
      // R3 / R4 carry-over behaviour
      drive(1, 10, 2, 8, 32, 0, "R3");
      drive(1, 1, 1, 8, 32, 0, "R4");
      drive(1, 2, 1, 8, 32, 0, "R4");
      drive(1, 4, 1, 8, 32, 0, "R2");
      drive(1, 9, 1, 8, 32, 0, "R3");
      drive(1, 0, 0, 8, 32, 0, "R4");
      drive(1, 9, 1, 8, 32, 0, "R3");
      drive(1, 9, 1, 8, 32, 0, "R3");
      drive(1, 3, 1, 8, 32, 0, "R9");
      drive(1, 2, 1, 8, 32, 0, "R9");
      drive(1, 15, 0, 8, 32, 0, "R3");
      drive(0, 0, 0, 8, 32, 0, "R4");
      drive(1, 1, 0, 8, 32, 0, "R4");
      drive(1, 2, 0, 8, 32, 0, "R4");
      // R5 rename capacity
      drive(1, 2, 5, 4, 32, 0, "R5");
      drive(1, 2, 4, 4, 32, 0, "R5");
      // R6 retire queue capacity
      drive(1, 5, 1, 8, 4, 0, "R6");
      drive(1, 4, 1, 8, 4, 0, "R6");
      // R7 scheduler codes
      drive(1, 1, 1, 8, 32, 1, "R7");
      drive(1, 1, 1, 8, 32, 2, "R7");
      drive(1, 1, 1, 8, 32, 3, "R7");
      drive(1, 1, 1, 8, 32, 4, "R7");
      drive(1, 1, 1, 8, 32, 7, "R7");
      // R8 priority ranking
      drive(1, 6, 7, 2, 3, 2, "R8");
      drive(1, 6, 1, 8, 3, 2, "R8");
      drive(1, 12, 1, 8, 32, 0, "R8");
      drive(1, 6, 1, 8, 32, 3, "R8");
      drive(1, 5, 1, 8, 32, 0, "R8");
      // R10 saturation of the rename counter
      for (int i = 0; i < CMAX + 4; i++) drive(1, 1, 6, 2, 32, 0, "R10");
      drive(1, 1, 1, 8, 32, 1, "R10");
      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule